// File: doc/BRIEF.md
# I2C Byte-Addressed EEPROM Target

This block is the bus-facing logic of a serial EEPROM. It listens to an I2C pair (SCL and SDA) that it samples with a much faster system clock. It answers to one of four device addresses chosen by two strap inputs. Data bytes pass between the bus and a 16,384-byte storage array through a synchronous memory port. The array sits beside the block and answers reads one clock after the address is presented.

A master selects the device and sends a two-byte word address, high byte first. It then either streams data bytes to be written or issues a repeated START and reads back. Written bytes are staged in a one-page buffer and reach the array only when a STOP closes the transfer. After that commit an internal write interval runs for a parameterized number of clocks. During that interval the block ignores its address, so masters poll it until it acknowledges again. A write-protect input leaves the whole array read-only.

Top module: `i2c_eeprom_target`

## Requirements
- R1: Out of reset the block does not pull SDA low and issues no array writes.
- R2: The block acknowledges a select byte only when bits 7..4 equal 1010, bit 3 is 0, bit 2 equals strap_a1 and bit 1 equals strap_a0; bit 0 selects read (1) or write (0). Any other select byte gets no acknowledge.
- R3: The word address is received high byte first. Of the high byte only bits 5..0 count, so bits 7..6 have no effect on the location accessed.
- R4: Write data bytes go to consecutive locations. The low 6 address bits wrap inside the 64-byte page that the word address names, and the upper 8 address bits stay fixed.
- R5: Staged bytes are committed only by a STOP at a byte boundary after at least one data byte. A STOP before any data byte, or a START or STOP partway through a data byte, commits nothing.
- R6: While wp is high, data bytes are still acknowledged but the array is left unchanged and no write interval starts.
- R7: After a commit the block refuses its select byte for WRITE_CYCLES clocks and acknowledges it again afterwards.
- R8: A random read (write select, word address, repeated START, read select) returns the byte stored at that address.
- R9: A sequential read returns consecutive bytes while the master acknowledges each one, and the address rolls over from 16383 to 0.
- R10: A read select without a word address starts at the current address counter. After a read this is one past the last byte handed out. After a write it is one past the last byte written, wrapped inside the page.
- R11: In read data the block pulls SDA low only for 0 bits. After the master declines a byte, the block leaves SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired level) |
| strap_a0 | input | 1 | Address strap, low bit; tie low when unused |
| strap_a1 | input | 1 | Address strap, high bit; tie low when unused |
| wp | input | 1 | High blocks every write to the array |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| mem_addr | output | 14 | Array address for reads and commits |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, one clock after mem_addr |

## Verification
The assertions take for granted that SCL is oversampled, with every SCL level held for several system clocks. They also assume SDA moves only while SCL is low, except for START and STOP, and that the array port answers one clock after its address. The bench drives the bus with quarter-bit phases of six clocks and changes data only in the low phase of SCL. It releases SDA after each acknowledge it gives. Random page writes, reads and address choices come from a seeded generator, and directed cases cover the page wrap, the array rollover, aborted transfers, write protection and busy polling.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int DEF_ADDR_W       = 14;
    localparam int DEF_PAGE_W       = 6;
    localparam int DEF_WRITE_CYCLES = 1000;
    localparam logic [3:0] SEL_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_ACK_DEV, ST_ADDR_HI, ST_ACK_HI, ST_ADDR_LO,
        ST_ACK_LO, ST_WDATA, ST_ACK_W, ST_RDATA, ST_ACK_R, ST_WAIT
    } bus_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    function automatic logic sel_match(input logic [7:0] b, input logic a1, input logic a0);
        return b[7:1] == {SEL_CODE, 1'b0, a1, a0};
    endfunction

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense
    import eeprom_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_s, sda_s;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s <= '1;
            sda_s <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
            sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
            scl_q <= scl_s[SYNC_STAGES-1];
            sda_q <= sda_s[SYNC_STAGES-1];
        end
    end

    always_comb begin
        ev.scl_rise = scl_s[SYNC_STAGES-1] & ~scl_q;
        ev.scl_fall = ~scl_s[SYNC_STAGES-1] & scl_q;
        ev.start    = scl_s[SYNC_STAGES-1] & scl_q & sda_q & ~sda_s[SYNC_STAGES-1];
        ev.stop     = scl_s[SYNC_STAGES-1] & scl_q & ~sda_q & sda_s[SYNC_STAGES-1];
        ev.sda      = sda_s[SYNC_STAGES-1];
    end
endmodule

// File: rtl/eeprom_page_stage.sv
module eeprom_page_stage #(
    parameter int ADDR_W       = 14,
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stage_we,
    input  logic [PAGE_W-1:0]        stage_idx,
    input  logic [7:0]               stage_data,
    input  logic                     clear,
    input  logic                     commit_req,
    input  logic [ADDR_W-PAGE_W-1:0] page_sel,
    output logic                     busy,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_waddr,
    output logic [7:0]               mem_wdata
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

    logic [7:0]              pg_mem [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]   mask;
    logic [CNT_W-1:0]        cnt;
    logic [ADDR_W-PAGE_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask   <= '0;
            busy   <= 1'b0;
            cnt    <= '0;
            page_q <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(WRITE_CYCLES - 1)) begin
                busy <= 1'b0;
                mask <= '0;
            end
        end else if (commit_req && |mask) begin
            busy   <= 1'b1;
            cnt    <= '0;
            page_q <= page_sel;
        end else if (clear) begin
            mask <= '0;
        end else if (stage_we) begin
            mask[stage_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (stage_we && !busy) pg_mem[stage_idx] <= stage_data;
    end

    always_comb begin
        mem_we    = busy && (cnt < CNT_W'(PAGE_BYTES)) && mask[cnt[PAGE_W-1:0]];
        mem_waddr = {page_q, cnt[PAGE_W-1:0]};
        mem_wdata = pg_mem[cnt[PAGE_W-1:0]];
    end

    p_busy_span_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cnt) == CNT_W'(WRITE_CYCLES - 1));
    p_stage_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !stage_we);
    p_commit_starts_r5: assert property (@(posedge clk) disable iff (rst)
        (commit_req && !busy && |mask) |=> busy);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eeprom_pkg::*;
#(
    parameter int ADDR_W       = DEF_ADDR_W,
    parameter int PAGE_W       = DEF_PAGE_W,
    parameter int WRITE_CYCLES = DEF_WRITE_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_a0,
    input  logic              strap_a1,
    input  logic              wp,
    output logic              sda_drive_low,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int HI_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
    localparam logic [PAGE_W-1:0] PG_ONE   = 1;

    line_ev_t          ev;
    bus_state_t        state;
    logic [7:0]        shreg;
    logic [3:0]        bit_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [HI_W-1:0]   addr_hi;
    logic              rd_q, m_ack;
    logic              busy, st_we, byte_done;
    logic [ADDR_W-1:0] st_waddr;
    logic              stage_we, stage_clear, commit_req;

    i2c_line_sense u_sense (.clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev));

    assign byte_done   = ev.scl_fall && (bit_cnt == 4'd8);
    assign stage_we    = (state == ST_WDATA) && byte_done && !wp;
    assign stage_clear = (state == ST_ADDR_HI) && byte_done;
    assign commit_req  = ev.stop && (state == ST_WDATA) && (bit_cnt <= 4'd1);

    eeprom_page_stage #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_stage (
        .clk(clk), .rst(rst), .stage_we(stage_we), .stage_idx(addr_q[PAGE_W-1:0]),
        .stage_data(shreg), .clear(stage_clear), .commit_req(commit_req),
        .page_sel(addr_q[ADDR_W-1:PAGE_W]), .busy(busy), .mem_we(st_we),
        .mem_waddr(st_waddr), .mem_wdata(mem_wdata)
    );

    assign mem_we   = st_we;
    assign mem_addr = busy ? st_waddr : addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            shreg         <= '0;
            bit_cnt       <= '0;
            addr_q        <= '0;
            addr_hi       <= '0;
            rd_q          <= 1'b0;
            m_ack         <= 1'b0;
            sda_drive_low <= 1'b0;
        end else if (ev.start) begin
            state         <= ST_DEV;
            bit_cnt       <= '0;
            sda_drive_low <= 1'b0;
        end else if (ev.stop) begin
            state         <= ST_IDLE;
            sda_drive_low <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                    if (ev.scl_rise && bit_cnt < 4'd8) begin
                        shreg   <= {shreg[6:0], ev.sda};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        case (state)
                            ST_DEV: begin
                                if (sel_match(shreg, strap_a1, strap_a0) && !busy) begin
                                    sda_drive_low <= 1'b1;
                                    rd_q          <= shreg[0];
                                    state         <= ST_ACK_DEV;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end
                            ST_ADDR_HI: begin
                                addr_hi       <= shreg[HI_W-1:0];
                                sda_drive_low <= 1'b1;
                                state         <= ST_ACK_HI;
                            end
                            ST_ADDR_LO: begin
                                addr_q        <= {addr_hi, shreg};
                                sda_drive_low <= 1'b1;
                                state         <= ST_ACK_LO;
                            end
                            default: begin
                                addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PG_ONE;
                                sda_drive_low      <= 1'b1;
                                state              <= ST_ACK_W;
                            end
                        endcase
                    end
                end
                ST_ACK_DEV: begin
                    if (ev.scl_fall) begin
                        if (rd_q) begin
                            shreg         <= mem_rdata;
                            sda_drive_low <= ~mem_rdata[7];
                            bit_cnt       <= '0;
                            addr_q        <= addr_q + ADDR_ONE;
                            state         <= ST_RDATA;
                        end else begin
                            sda_drive_low <= 1'b0;
                            state         <= ST_ADDR_HI;
                        end
                    end
                end
                ST_ACK_HI: if (ev.scl_fall) begin sda_drive_low <= 1'b0; state <= ST_ADDR_LO; end
                ST_ACK_LO: if (ev.scl_fall) begin sda_drive_low <= 1'b0; state <= ST_WDATA; end
                ST_ACK_W:  if (ev.scl_fall) begin sda_drive_low <= 1'b0; state <= ST_WDATA; end
                ST_RDATA: begin
                    if (ev.scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            sda_drive_low <= 1'b0;
                            state         <= ST_ACK_R;
                        end else begin
                            shreg         <= {shreg[6:0], 1'b0};
                            sda_drive_low <= ~shreg[6];
                            bit_cnt       <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_ACK_R: begin
                    if (ev.scl_rise) m_ack <= ~ev.sda;
                    if (ev.scl_fall) begin
                        if (m_ack) begin
                            shreg         <= mem_rdata;
                            sda_drive_low <= ~mem_rdata[7];
                            bit_cnt       <= '0;
                            addr_q        <= addr_q + ADDR_ONE;
                            state         <= ST_RDATA;
                        end else begin
                            sda_drive_low <= 1'b0;
                            state         <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    p_no_drive_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_drive_low);
    p_dev_ack_not_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK_DEV) |-> !busy);
    p_we_quiet_bus_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (state == ST_IDLE || state == ST_DEV || state == ST_WAIT));
    p_no_drive_after_nack_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !sda_drive_low);
endmodule

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int MEMSZ      = 16384;
    localparam int WC         = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic a0_s = 1'b0, a1_s = 1'b1, wp_s = 1'b0;
    logic sda_drive_low, mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic sda_bus;
    logic [7:0] sim_mem [MEMSZ];
    logic [7:0] ref_mem [MEMSZ];
    int model_addr = 0;
    int cyc = 0;
    int total = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;
    assign sda_bus = sda_m & ~sda_drive_low;

    always @(posedge clk) begin
        if (mem_we) sim_mem[mem_addr] <= mem_wdata;
        mem_rdata <= sim_mem[mem_addr];
    end

    i2c_eeprom_target #(.ADDR_W(14), .PAGE_W(6), .WRITE_CYCLES(WC)) dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .strap_a0(a0_s),
        .strap_a1(a1_s), .wp(wp_s), .sda_drive_low(sda_drive_low), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sel_byte(input bit rd);
        return {4'b1010, 1'b0, a1_s, a0_s, rd};
    endfunction

    function automatic int in_page(input int base, input int k);
        return (base & ~63) | ((base + k) & 63);
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1; wt(Q); scl_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(Q);
    endtask

    task automatic bstop();
        sda_m = 0; wt(Q); scl_m = 1; wt(Q); sda_m = 1; wt(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i >= 8 - n; i--) begin
            sda_m = b[i]; wt(Q); scl_m = 1; wt(Q); scl_m = 0; wt(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1; wt(Q); scl_m = 1; wt(Q/2); ack = ~sda_bus; wt(Q/2); scl_m = 0; wt(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q); scl_m = 1; wt(Q/2); b[i] = sda_bus; wt(Q/2); scl_m = 0; wt(Q);
        end
        sda_m = mack ? 1'b0 : 1'b1;
        wt(Q); scl_m = 1; wt(Q); scl_m = 0; wt(1); sda_m = 1; wt(Q);
    endtask

    task automatic addr_phase(input int addr, input logic [1:0] junk, input string req);
        logic ack;
        bstart();
        send_byte(sel_byte(0), ack);             check(ack, req, ack, 1);
        send_byte({junk, 6'(addr >> 8)}, ack);   check(ack, "R3", ack, 1);
        send_byte(8'(addr), ack);                check(ack, "R3", ack, 1);
    endtask

    task automatic write_txn(input int addr, input int len, input logic [1:0] junk, input string req);
        logic ack;
        logic [7:0] d;
        addr_phase(addr, junk, req);
        for (int k = 0; k < len; k++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            check(ack, req, ack, 1);
            if (!wp_s) ref_mem[in_page(addr, k)] = d;
        end
        bstop();
        model_addr = (len > 0) ? in_page(addr, len) : addr;
    endtask

    task automatic recv_run(input int len, input string req);
        logic [7:0] b;
        for (int k = 0; k < len; k++) begin
            recv_byte(b, k != len - 1);
            check(b == ref_mem[model_addr], req, b, ref_mem[model_addr]);
            model_addr = (model_addr + 1) % MEMSZ;
        end
        wt(Q);
        check(sda_drive_low == 1'b0, "R11", sda_drive_low, 0);
    endtask

    task automatic random_read(input int addr, input int len, input string req);
        logic ack;
        addr_phase(addr, 2'b00, "R8");
        bstart();
        send_byte(sel_byte(1), ack); check(ack, "R8", ack, 1);
        model_addr = addr;
        recv_run(len, req);
        bstop();
    endtask

    task automatic cur_read(input int len, input string req);
        logic ack;
        bstart();
        send_byte(sel_byte(1), ack); check(ack, req, ack, 1);
        recv_run(len, req);
        bstop();
    endtask

    task automatic poll(output int nacks, output int waited);
        logic ack;
        int t0;
        t0 = cyc; nacks = 0; ack = 0;
        for (int n = 0; n < 60 && !ack; n++) begin
            bstart();
            send_byte(sel_byte(0), ack);
            waited = cyc - t0;
            bstop();
            if (!ack) nacks++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic ack;
        int nk, wtd, base, ln;
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < MEMSZ; i++) begin sim_mem[i] = 8'h00; ref_mem[i] = 8'h00; end
        wt(5); rst = 0; wt(5);
        check(sda_drive_low == 0, "R1", sda_drive_low, 0);
        check(mem_we == 0, "R1", mem_we, 0);

        // R2: strap and code mismatches are refused
        bstart(); send_byte(8'hA6, ack); bstop(); check(!ack, "R2", ack, 0);
        bstart(); send_byte(8'hAC, ack); bstop(); check(!ack, "R2", ack, 0);
        bstart(); send_byte(8'hB4, ack); bstop(); check(!ack, "R2", ack, 0);
        bstart(); send_byte(8'hA4, ack); bstop(); check(ack, "R2", ack, 1);
        a1_s = 0; a0_s = 1; wt(4);
        bstart(); send_byte(8'hA4, ack); bstop(); check(!ack, "R2", ack, 0);
        bstart(); send_byte(8'hA2, ack); bstop(); check(ack, "R2", ack, 1);

        // R3/R7: byte write with junk upper address bits, then busy polling
        write_txn(16'h1234 & 14'h3fff, 1, 2'b11, "R3");
        poll(nk, wtd);
        check(nk >= 1, "R7", nk, 1);
        check(wtd >= WC - 2*Q, "R7", wtd, WC);
        check(wtd <= WC + 500, "R7", wtd, WC);
        // R5: STOP before data leaves no busy window
        poll(nk, wtd); check(nk == 0, "R5", nk, 0);
        random_read(16'h1234 & 14'h3fff, 1, "R8");

        // R4/R10: page write wrapping from offset 60
        write_txn(14'h0ABC, 8, 2'b00, "R4");
        poll(nk, wtd); check(nk >= 1, "R7", nk, 1);
        cur_read(1, "R10");
        random_read(14'h0A80, 64, "R4");

        // R6: write protect
        wp_s = 1;
        write_txn(14'h0A80, 3, 2'b00, "R6");
        poll(nk, wtd); check(nk == 0, "R6", nk, 0);
        wp_s = 0;
        random_read(14'h0A80, 3, "R6");

        // R5: STOP partway through a data byte aborts
        addr_phase(14'h0300, 2'b00, "R5");
        send_byte(8'h5A, ack); send_bits(8'hFF, 4); bstop();
        poll(nk, wtd); check(nk == 0, "R5", nk, 0);
        random_read(14'h0300, 1, "R5");
        // R5: START partway through a data byte aborts
        addr_phase(14'h0301, 2'b00, "R5");
        send_byte(8'hC3, ack); send_bits(8'h00, 3); bstart();
        send_byte(sel_byte(0), ack); bstop();
        poll(nk, wtd); check(nk == 0, "R5", nk, 0);
        random_read(14'h0300, 2, "R5");

        // R9/R10: sequential read across the top of the array
        write_txn(14'h3FFE, 2, 2'b00, "R4");
        poll(nk, wtd);
        write_txn(14'h0000, 3, 2'b00, "R4");
        poll(nk, wtd);
        random_read(14'h3FFE, 4, "R9");
        cur_read(2, "R10");

        // random page writes and reads
        for (int it = 0; it < 7; it++) begin
            base = int'($urandom % MEMSZ);
            ln   = 1 + int'($urandom % 24);
            write_txn(base, ln, 2'($urandom), "R4");
            poll(nk, wtd);
            check(nk >= 1, "R7", nk, 1);
            random_read(base & ~63, 1 + int'($urandom % 20), "R9");
            random_read(int'($urandom % MEMSZ), 1 + int'($urandom % 6), "R8");
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule